// File: doc/BRIEF.md
# Button-Driven Display Mode Sequencer

This controller takes one clean, already synchronised push-button level and uses it to pick which of four display sources a downstream multiplexer shows. The sources are time, alarm, date and stopwatch. Each new press moves the selection to the next source and wraps after the last one. Every press also produces one acknowledgement beep that lasts exactly one clock cycle. A button held down counts as a single press, and the button must be released before it can advance the selection again.

The select output is registered and depends only on the stored mode. A parameter chooses how the beep is formed:

- **Arc beep:** the beep is decoded from the stored state together with the live button level. It appears in the same cycle in which the rising button is first seen.
- **State beep:** the beep comes from a dedicated one-cycle pulse state that follows each press. Together with the four mode states this gives eight states. The beep then shows one cycle later, in step with the new selection.

All ports are plain control levels, so there is no stream handshake.

Top module: `mode_sequencer`

## Requirements
- R1: A synchronous reset puts the selection at time (`sel`=0) and holds `beep` low. After reset the button must be seen low before a press counts, so a button held through reset neither advances nor beeps.
- R2: The `sel` encoding is 0 time, 1 alarm, 2 date, 3 stopwatch. Each counted press moves `sel` one step in the order 0, 1, 2, 3 and then back to 0.
- R3: Each counted press drives `beep` high for exactly one clock cycle, and no beep occurs without a press.
- R4: A press is counted only on a low-to-high change of `btn` between consecutive clock samples. Holding `btn` high for any number of cycles gives one advance and one beep.
- R5: With `BEEP_ON_ARC`=1, `beep` is high in the same cycle that `btn` is first high after being low. `sel` shows the new mode from the next clock edge.
- R6: With `BEEP_ON_ARC`=0, `beep` is registered. It is high in the cycle after the press cycle, the same cycle in which `sel` first shows the new mode.
- R7: `sel` is registered and changes only at a clock edge that follows a counted press.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| btn | input | 1 | Button level, 1 while pressed, already debounced and synchronised |
| sel | output | SEL_W (2) | Display source select: 0 time, 1 alarm, 2 date, 3 stopwatch |
| beep | output | 1 | One-cycle beep request per counted press |

## Verification
On every cycle, the assertions check four things:
- `sel` only ever moves one step in the wrap-around order;
- `sel` never moves unless the button has just risen;
- a held button never moves `sel`;
- a beep never lasts two cycles and always coincides with a selection step in the timing of the chosen variant.

Only the bench's scenarios can show the following, because each needs a model that counts presses over a whole input history:
- that every press is counted, with none lost;
- that the arming rule after reset holds;
- the exact cycle relation between a button edge and the beep in both variants.

The bench runs both variants side by side over every 9-cycle button pattern, and also runs a long hold.

// File: rtl/mseq_pkg.sv
package mseq_pkg;
  typedef enum logic [1:0] {
    MODE_TIME      = 2'd0,
    MODE_ALARM     = 2'd1,
    MODE_DATE      = 2'd2,
    MODE_STOPWATCH = 2'd3
  } mode_e;

  localparam int unsigned MODE_COUNT = 4;
endpackage

// File: rtl/mseq_press_detect.sv
module mseq_press_detect (
  input  logic clk,
  input  logic rst,
  input  logic btn,
  output logic press
);
  // btn_q resets high: the button must be observed released before arming
  logic btn_q;

  always_ff @(posedge clk) begin
    if (rst) btn_q <= 1'b1;
    else     btn_q <= btn;
  end

  assign press = !rst && btn && !btn_q;
endmodule

// File: rtl/mseq_mode_reg.sv
module mseq_mode_reg #(
  parameter int unsigned NUM_MODES = 4,
  parameter int unsigned SEL_W     = $clog2(NUM_MODES)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             advance,
  output logic [SEL_W-1:0] sel
);
  localparam logic [SEL_W-1:0] LAST = SEL_W'(NUM_MODES - 1);

  logic [SEL_W-1:0] mode_q;

  always_ff @(posedge clk) begin
    if (rst)               mode_q <= '0;
    else if (advance) begin
      if (mode_q == LAST)  mode_q <= '0;
      else                 mode_q <= mode_q + SEL_W'(1);
    end
  end

  assign sel = mode_q;
endmodule

// File: rtl/mseq_beep_unit.sv
module mseq_beep_unit #(
  parameter bit BEEP_ON_ARC = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic press,
  output logic beep
);
  generate
    if (BEEP_ON_ARC) begin : g_arc
      // output decoded on the transition: state plus live input
      assign beep = press;
    end else begin : g_state
      // dedicated pulse state entered for one cycle after each press
      logic pulse_q;
      always_ff @(posedge clk) begin
        if (rst) pulse_q <= 1'b0;
        else     pulse_q <= press;
      end
      assign beep = pulse_q;
    end
  endgenerate
endmodule

// File: rtl/mode_sequencer.sv
module mode_sequencer #(
  parameter int unsigned NUM_MODES   = mseq_pkg::MODE_COUNT,
  parameter bit          BEEP_ON_ARC = 1'b1,
  localparam int unsigned SEL_W      = $clog2(NUM_MODES)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             btn,
  output logic [SEL_W-1:0] sel,
  output logic             beep
);
  logic press;

  mseq_press_detect u_press (
    .clk   (clk),
    .rst   (rst),
    .btn   (btn),
    .press (press)
  );

  mseq_mode_reg #(
    .NUM_MODES (NUM_MODES),
    .SEL_W     (SEL_W)
  ) u_mode (
    .clk     (clk),
    .rst     (rst),
    .advance (press),
    .sel     (sel)
  );

  mseq_beep_unit #(
    .BEEP_ON_ARC (BEEP_ON_ARC)
  ) u_beep (
    .clk   (clk),
    .rst   (rst),
    .press (press),
    .beep  (beep)
  );
endmodule

// File: rtl/mode_sequencer_chk.sv
module mode_sequencer_chk #(
  parameter int unsigned NUM_MODES   = 4,
  parameter int unsigned SEL_W       = 2,
  parameter bit          BEEP_ON_ARC = 1'b1
) (
  input logic             clk,
  input logic             rst,
  input logic             btn,
  input logic [SEL_W-1:0] sel,
  input logic             beep
);
  localparam logic [SEL_W-1:0] LAST = SEL_W'(NUM_MODES - 1);

  AST_SEL_WRAP_ORDER: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && sel != $past(sel)) |->
      (sel == (($past(sel) == LAST) ? '0 : $past(sel) + SEL_W'(1)))); // R2

  AST_SEL_NEEDS_EDGE: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && sel != $past(sel)) |->
      ($past(btn) && !$past(btn, 2))); // R7

  AST_HELD_NO_STEP: assert property (@(posedge clk) disable iff (rst)
    (btn && $past(btn) && !$past(rst)) |=> $stable(sel)); // R4

  AST_BEEP_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    beep |=> !beep); // R3

  generate
    if (BEEP_ON_ARC) begin : g_arc
      AST_ARC_BEEP_STEPS: assert property (@(posedge clk) disable iff (rst)
        beep |=> (sel != $past(sel))); // R5
    end else begin : g_state
      AST_STATE_BEEP_STEPS: assert property (@(posedge clk) disable iff (rst)
        (beep && !$past(rst)) |-> (sel != $past(sel))); // R6
    end
  endgenerate
endmodule

bind mode_sequencer mode_sequencer_chk #(
  .NUM_MODES   (NUM_MODES),
  .SEL_W       (SEL_W),
  .BEEP_ON_ARC (BEEP_ON_ARC)
) u_chk (
  .clk  (clk),
  .rst  (rst),
  .btn  (btn),
  .sel  (sel),
  .beep (beep)
);

// File: tb/mode_sequencer_test.sv
module mode_sequencer_test;
  import mseq_pkg::*;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       btn = 1'b0;
  logic [1:0] sel_a, sel_s;
  logic       beep_a, beep_s;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  // model state
  int presses  = 0;
  bit prev_btn = 1'b1;
  bit beep_due = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  mode_sequencer #(.NUM_MODES(4), .BEEP_ON_ARC(1'b1)) uut (
    .clk(clk), .rst(rst), .btn(btn), .sel(sel_a), .beep(beep_a));

  mode_sequencer #(.NUM_MODES(4), .BEEP_ON_ARC(1'b0)) uut_moore (
    .clk(clk), .rst(rst), .btn(btn), .sel(sel_s), .beep(beep_s));

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic summary();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=0", cycles);
      summary();
    end
  end

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    btn = 1'b0;
    @(posedge clk);
    #1;
    check("R1 sel after reset", sel_a, MODE_TIME);
    check("R1 sel after reset (state beep)", sel_s, MODE_TIME);
    check("R1 beep after reset", beep_a, 0);
    check("R1 beep after reset (state beep)", beep_s, 0);
    presses  = 0;
    prev_btn = 1'b1;  // must see release before arming
    beep_due = 1'b0;
  endtask

  task automatic step(bit b);
    bit press;
    @(negedge clk);
    rst = 1'b0;
    btn = b;
    #2;
    press = b && !prev_btn;
    check("R2 R7 sel arc variant", sel_a, presses % 4);
    check("R2 R7 sel state variant", sel_s, presses % 4);
    check("R3 R5 arc beep", beep_a, press);
    check("R3 R6 state beep", beep_s, beep_due);
    beep_due = press;
    if (press) presses++;
    prev_btn = b;
  endtask

  initial begin
    // R1: the button is held across reset, so release must be seen first
    do_reset();
    btn = 1'b1;
    step(1'b1);
    step(1'b1);
    step(1'b0);
    step(1'b1);
    step(1'b0);

    // exhaustive sweep over 9-cycle button patterns (R2..R7)
    for (int pat = 0; pat < 512; pat++) begin
      do_reset();
      for (int i = 0; i < 9; i++) step(pat[i]);
      step(1'b0);
    end

    // R4: a long hold gives one advance, then presses continue to wrap
    do_reset();
    step(1'b0);
    for (int i = 0; i < 60; i++) step(1'b1);
    step(1'b0);
    for (int k = 0; k < 9; k++) begin
      step(1'b1);
      step(1'b1);
      step(1'b0);
    end
    check("R4 total presses after long hold", presses, 10);
    step(1'b0);

    summary();
  end
endmodule